// File: doc/BRIEF.md
# Mask-and-Use Instruction Fusion Detector

This block sits in the decode stage of a RISC-V pipeline. Each cycle it looks at two consecutive 32-bit instructions. The first may be a register-register AND that writes a mask result, and the second may consume that result. When the second is a load that uses the AND result as its base register, the pair becomes one load-under-mask micro-operation. That operation computes the address as (rX & rM) + displacement and writes the loaded value to the load's destination. When the second is a BEQ or BNE that compares the AND result against x0, the pair becomes one masked bit-test branch. It is taken when the masked value is zero (BEQ) or non-zero (BNE).

The fused operation still names rY as a destination, so the register file must receive rX & rM exactly as it would after unfused execution. Any pair that does not match leaves through two pass-through slots, bit for bit unchanged, and the downstream pipeline issues it as two operations. All outputs are registered, so results appear one clock after the pair is presented.

Top module: `mask_fuse_detect`

## Requirements
- R1: The first instruction counts as an AND only when opcode [6:0] is 0110011, funct3 [14:12] is 111 and funct7 [31:25] is 0000000. Any other first instruction prevents fusion, including OR (funct3 110) and funct7 0100000.
- R2: A valid AND rY,rX,rM followed by a valid load (opcode 0000011, funct3 not 111) whose base rs1 [19:15] equals rY gives fuse_vld_o=1 and fuse_kind_o=01. The outputs then carry src_reg_o=rX, mask_reg_o=rM and and_dst_o=rY.
- R3: For a fused load, ld_dst_o holds the load's rd [11:7] and ld_size_o holds the load's funct3 (width and sign). imm_o holds the 12-bit displacement [31:20], sign-extended to XLEN.
- R4: An AND followed by BNE (opcode 1100011, funct3 001) comparing rY with x0 fuses with fuse_kind_o=11, a branch taken when (rX & rM) is non-zero.
- R5: An AND followed by BEQ (opcode 1100011, funct3 000) comparing rY with x0 fuses with fuse_kind_o=10, a branch taken when (rX & rM) is zero.
- R6: The branch is accepted with either operand order: rs1=rY with rs2=x0, or rs1=x0 with rs2=rY.
- R7: For a fused branch, imm_o holds the 13-bit branch offset rebuilt from bits {31,7,30:25,11:8} with bit 0 zero, sign-extended to XLEN.
- R8: No fusion occurs when the second instruction does not consume rY. Examples: a load base other than rY, a branch whose other operand is not x0, a branch funct3 other than 000/001, a load with funct3 111.
- R9: No fusion occurs when rY is x0, or when either instruction's valid input is low.
- R10: With no fusion, slot0_o/slot1_o carry the two instructions unchanged, slot0_vld_o/slot1_vld_o equal the input valids, and fuse_kind_o is 00. With fusion, both slot valids are low.
- R11: All outputs change one clock after the inputs. While rst_n is low, every valid output is 0 and fuse_kind_o is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld0_i | input | 1 | First instruction valid |
| ins0_i | input | 32 | First (older) instruction |
| vld1_i | input | 1 | Second instruction valid |
| ins1_i | input | 32 | Second (younger) instruction |
| fuse_vld_o | output | 1 | A fused micro-operation is issued |
| fuse_kind_o | output | 2 | 00 none, 01 masked load, 10 masked BEQ, 11 masked BNE |
| src_reg_o | output | 5 | rX, value operand of the AND |
| mask_reg_o | output | 5 | rM, mask operand of the AND |
| and_dst_o | output | 5 | rY, still written with rX & rM |
| ld_dst_o | output | 5 | Load destination rZ |
| ld_size_o | output | 3 | Load funct3: width and sign |
| imm_o | output | XLEN | Sign-extended displacement or branch offset |
| slot0_vld_o | output | 1 | First instruction issues separately |
| slot0_o | output | 32 | First instruction, unchanged |
| slot1_vld_o | output | 1 | Second instruction issues separately |
| slot1_o | output | 32 | Second instruction, unchanged |

## Verification
The bench targets the dependency check. A load whose base is a different register, or a branch whose second operand is not x0, must not fuse; a design that compared only opcodes would fuse these pairs and lose the real operand. It also sends a branch with x0 as the first operand and rY as the second; a design that checked only rs1 would let this legal pair through unfused. Destination x0, a dropped valid, OR and funct7-altered ANDs are sent too: fusing any of them would create a dependency that does not exist. Branch offsets at both extremes (+4094 and -4096) catch a misplaced bit 11 or bit 12 in the reassembled offset.

// File: rtl/mask_fuse_detect.sv
`timescale 1ns/1ps
module mask_fuse_detect #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld0_i,
  input  logic [31:0]     ins0_i,
  input  logic            vld1_i,
  input  logic [31:0]     ins1_i,
  output logic            fuse_vld_o,
  output logic [1:0]      fuse_kind_o,
  output logic [4:0]      src_reg_o,
  output logic [4:0]      mask_reg_o,
  output logic [4:0]      and_dst_o,
  output logic [4:0]      ld_dst_o,
  output logic [2:0]      ld_size_o,
  output logic [XLEN-1:0] imm_o,
  output logic            slot0_vld_o,
  output logic [31:0]     slot0_o,
  output logic            slot1_vld_o,
  output logic [31:0]     slot1_o
);
  localparam logic [1:0] K_NONE = 2'b00;
  localparam logic [1:0] K_LOAD = 2'b01;
  localparam logic [1:0] K_BEQ  = 2'b10;
  localparam logic [1:0] K_BNE  = 2'b11;

  wire [4:0] a_rd  = ins0_i[11:7];
  wire [4:0] a_rs1 = ins0_i[19:15];
  wire [4:0] a_rs2 = ins0_i[24:20];
  wire [4:0] b_rd  = ins1_i[11:7];
  wire [4:0] b_rs1 = ins1_i[19:15];
  wire [4:0] b_rs2 = ins1_i[24:20];
  wire [2:0] b_f3  = ins1_i[14:12];

  wire is_and = ins0_i[6:0] == 7'b0110011 && ins0_i[14:12] == 3'b111 &&
                ins0_i[31:25] == 7'b0000000;
  wire is_ld  = ins1_i[6:0] == 7'b0000011 && b_f3 != 3'b111;
  wire is_br  = ins1_i[6:0] == 7'b1100011 && b_f3[2:1] == 2'b00;

  wire base_ok = vld0_i && vld1_i && is_and && a_rd != 5'd0;
  wire ld_hit  = base_ok && is_ld && b_rs1 == a_rd;
  wire br_hit  = base_ok && is_br &&
                 ((b_rs1 == a_rd && b_rs2 == 5'd0) || (b_rs1 == 5'd0 && b_rs2 == a_rd));
  wire hit     = ld_hit || br_hit;

  wire [XLEN-1:0] imm_ld = {{(XLEN-12){ins1_i[31]}}, ins1_i[31:20]};
  wire [XLEN-1:0] imm_br = {{(XLEN-13){ins1_i[31]}}, ins1_i[31], ins1_i[7],
                            ins1_i[30:25], ins1_i[11:8], 1'b0};

  logic [1:0] kind_n;
  assign kind_n = ld_hit ? K_LOAD : br_hit ? (b_f3[0] ? K_BNE : K_BEQ) : K_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fuse_vld_o  <= 1'b0;
      fuse_kind_o <= K_NONE;
      src_reg_o   <= '0;
      mask_reg_o  <= '0;
      and_dst_o   <= '0;
      ld_dst_o    <= '0;
      ld_size_o   <= '0;
      imm_o       <= '0;
      slot0_vld_o <= 1'b0;
      slot0_o     <= '0;
      slot1_vld_o <= 1'b0;
      slot1_o     <= '0;
    end else begin
      fuse_vld_o  <= hit;
      fuse_kind_o <= kind_n;
      src_reg_o   <= a_rs1;
      mask_reg_o  <= a_rs2;
      and_dst_o   <= a_rd;
      ld_dst_o    <= b_rd;
      ld_size_o   <= b_f3;
      imm_o       <= ld_hit ? imm_ld : imm_br;
      slot0_vld_o <= vld0_i && !hit;
      slot0_o     <= ins0_i;
      slot1_vld_o <= vld1_i && !hit;
      slot1_o     <= ins1_i;
    end
  end

  a_r9_no_x0_dest: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_vld_o |-> and_dst_o != 5'd0);
  a_r9_needs_both_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld0_i && vld1_i) |=> !fuse_vld_o);
  a_r10_slots_idle_on_fuse: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_vld_o |-> !slot0_vld_o && !slot1_vld_o);
  a_r10_kind_none_when_split: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_vld_o == (fuse_kind_o != K_NONE));
  a_r3_load_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_kind_o == K_LOAD) |-> ld_size_o != 3'b111);
  a_r7_branch_offset_even: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_kind_o[1]) |-> imm_o[0] == 1'b0);
  a_r11_slots_follow_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> slot0_o == $past(ins0_i) && slot1_o == $past(ins1_i));
endmodule

// File: tb/mask_fuse_detect_tb.sv
`timescale 1ns/1ps
module mask_fuse_detect_tb;
  logic clk = 0, rst_n = 0, vld0 = 0, vld1 = 0;
  logic [31:0] ins0 = 0, ins1 = 0;
  logic fuse_vld, s0v, s1v;
  logic [1:0] kind;
  logic [4:0] rx, rm, ry, rz;
  logic [2:0] sz;
  logic [31:0] imm, s0, s1;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mask_fuse_detect u_dut (
    .clk(clk), .rst_n(rst_n), .vld0_i(vld0), .ins0_i(ins0), .vld1_i(vld1), .ins1_i(ins1),
    .fuse_vld_o(fuse_vld), .fuse_kind_o(kind), .src_reg_o(rx), .mask_reg_o(rm),
    .and_dst_o(ry), .ld_dst_o(rz), .ld_size_o(sz), .imm_o(imm),
    .slot0_vld_o(s0v), .slot0_o(s0), .slot1_vld_o(s1v), .slot1_o(s1));

  function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [2:0] f3,
                                      input logic [4:0] rd, rs1, rs2);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] e_ld(input logic [4:0] rd, rs1, input logic [2:0] f3,
                                       input logic [11:0] d);
    return {d, rs1, f3, rd, 7'b0000011};
  endfunction
  function automatic logic [31:0] e_br(input logic [2:0] f3, input logic [4:0] rs1, rs2,
                                       input logic [12:0] o);
    return {o[12], o[10:5], rs2, rs1, f3, o[4:1], o[11], 7'b1100011};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v0, input logic [31:0] i0, input logic v1, input logic [31:0] i1);
    @(negedge clk);
    vld0 = v0; ins0 = i0; vld1 = v1; ins1 = i1;
    @(negedge clk);
  endtask

  task automatic expect_split(input string tag, input logic v0, v1);
    chk({tag, " fuse_vld"}, {31'b0, fuse_vld}, 0);
    chk({tag, " kind"}, {30'b0, kind}, 0);
    chk({tag, " slot0_vld"}, {31'b0, s0v}, {31'b0, v0});
    chk({tag, " slot1_vld"}, {31'b0, s1v}, {31'b0, v1});
    chk({tag, " slot0"}, s0, ins0);
    chk({tag, " slot1"}, s1, ins1);
  endtask

  task automatic t_reset;
    chk("R11 reset fuse_vld", {31'b0, fuse_vld}, 0);
    chk("R11 reset kind", {30'b0, kind}, 0);
    chk("R11 reset slot valids", {30'b0, s0v, s1v}, 0);
  endtask

  task automatic t_load;
    drive(1, e_r(7'd0, 3'b111, 5'd5, 5'd6, 5'd7), 1, e_ld(5'd9, 5'd5, 3'b010, 12'hFFC));
    chk("R2 fuse_vld", {31'b0, fuse_vld}, 1);
    chk("R2 kind load", {30'b0, kind}, 1);
    chk("R2 rX", {27'b0, rx}, 6);
    chk("R2 rM", {27'b0, rm}, 7);
    chk("R2 rY", {27'b0, ry}, 5);
    chk("R3 rZ", {27'b0, rz}, 9);
    chk("R3 size", {29'b0, sz}, 3'b010);
    chk("R3 imm negative", imm, 32'hFFFF_FFFC);
    chk("R10 slots idle", {30'b0, s0v, s1v}, 0);
    drive(1, e_r(7'd0, 3'b111, 5'd12, 5'd1, 5'd2), 1, e_ld(5'd12, 5'd12, 3'b100, 12'h7FF));
    chk("R3 lbu kind", {30'b0, kind}, 1);
    chk("R3 lbu size", {29'b0, sz}, 3'b100);
    chk("R3 imm positive", imm, 32'h0000_07FF);
    chk("R3 rZ equals rY", {27'b0, rz}, 12);
  endtask

  task automatic t_branch;
    drive(1, e_r(7'd0, 3'b111, 5'd3, 5'd10, 5'd11), 1, e_br(3'b001, 5'd3, 5'd0, 13'h1FF8));
    chk("R4 bne kind", {30'b0, kind}, 2'b11);
    chk("R4 bne fuse_vld", {31'b0, fuse_vld}, 1);
    chk("R7 offset -8", imm, 32'hFFFF_FFF8);
    chk("R4 rY", {27'b0, ry}, 3);
    drive(1, e_r(7'd0, 3'b111, 5'd3, 5'd10, 5'd11), 1, e_br(3'b000, 5'd3, 5'd0, 13'h0FFE));
    chk("R5 beq kind", {30'b0, kind}, 2'b10);
    chk("R7 offset +4094", imm, 32'h0000_0FFE);
    drive(1, e_r(7'd0, 3'b111, 5'd20, 5'd21, 5'd22), 1, e_br(3'b000, 5'd0, 5'd20, 13'h1000));
    chk("R6 swapped beq kind", {30'b0, kind}, 2'b10);
    chk("R7 offset -4096", imm, 32'hFFFF_F000);
    drive(1, e_r(7'd0, 3'b111, 5'd20, 5'd21, 5'd22), 1, e_br(3'b001, 5'd0, 5'd20, 13'h0010));
    chk("R6 swapped bne kind", {30'b0, kind}, 2'b11);
    chk("R6 swapped bne mask regs", {22'b0, rx, rm}, {22'b0, 5'd21, 5'd22});
  endtask

  task automatic t_no_dep;
    drive(1, e_r(7'd0, 3'b111, 5'd5, 5'd6, 5'd7), 1, e_ld(5'd9, 5'd8, 3'b010, 12'h004));
    expect_split("R8 other base", 1, 1);
    drive(1, e_r(7'd0, 3'b111, 5'd5, 5'd6, 5'd7), 1, e_br(3'b001, 5'd5, 5'd4, 13'h0008));
    expect_split("R8 nonzero compare", 1, 1);
    drive(1, e_r(7'd0, 3'b111, 5'd5, 5'd6, 5'd7), 1, e_br(3'b100, 5'd5, 5'd0, 13'h0008));
    expect_split("R8 blt", 1, 1);
    drive(1, e_r(7'd0, 3'b111, 5'd5, 5'd6, 5'd7), 1, e_ld(5'd9, 5'd5, 3'b111, 12'h004));
    expect_split("R8 load f3 111", 1, 1);
  endtask

  task automatic t_blocked;
    drive(1, e_r(7'd0, 3'b111, 5'd0, 5'd6, 5'd7), 1, e_ld(5'd9, 5'd0, 3'b010, 12'h0));
    expect_split("R9 rY x0", 1, 1);
    drive(0, e_r(7'd0, 3'b111, 5'd5, 5'd6, 5'd7), 1, e_ld(5'd9, 5'd5, 3'b010, 12'h0));
    expect_split("R9 vld0 low", 0, 1);
    drive(1, e_r(7'd0, 3'b111, 5'd5, 5'd6, 5'd7), 0, e_br(3'b000, 5'd5, 5'd0, 13'h8));
    expect_split("R9 vld1 low", 1, 0);
    drive(1, e_r(7'h20, 3'b111, 5'd5, 5'd6, 5'd7), 1, e_ld(5'd9, 5'd5, 3'b010, 12'h0));
    expect_split("R1 funct7 altered", 1, 1);
    drive(1, e_r(7'd0, 3'b110, 5'd5, 5'd6, 5'd7), 1, e_br(3'b001, 5'd5, 5'd0, 13'h8));
    expect_split("R1 OR not AND", 1, 1);
    drive(0, 32'h0, 0, 32'h0);
    expect_split("R10 idle", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_load;
    t_branch;
    t_no_dep;
    t_blocked;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule